// File: doc/BRIEF.md
# Nonvolatile Memory Control Register

This block is the 8-bit control and status register that a CPU uses to drive an on-chip nonvolatile memory. The memory can be a data EEPROM, program flash or configuration space. Software writes the register at one fixed address to choose the target, to arm writing and to request a read, a write or a row erase. The register drives a one-cycle read strobe and a one-cycle write-start or erase-start strobe toward the memory back end, and it presents the two target-select bits as outputs.

A small internal programming timer stands in for the self-timed programming engine. It counts a parameterised number of cycles after a start and then finishes the operation. When the operation finishes, hardware clears the start bit and the erase bit. The start bits are set-only: software can raise them, and only hardware clears them.

The block has two reset inputs. A power-on reset clears every bit. A warm reset stops any operation in flight and records the abort in an error flag. It leaves the target-select bits untouched, so the failed operation can still be traced.

Top module: `nvmCtlReg`

## Requirements
- R1: While `porRst` is high at a clock edge, the whole register is cleared: after that edge the register reads 0x00 and no strobe is high.
- R2: The register bits are as follows. Bit 7 selects program flash (drives `memSelProg`). Bit 6 selects configuration space (drives `memSelCfg`). Bit 5 always reads 0. Bit 4 is the row-erase enable. Bit 3 is the error flag. Bit 2 is the write enable. Bit 1 is the write start. Bit 0 is the read start. When idle, a CPU write to bits 7, 6, 4, 3 and 2 appears in the readback after the write's edge.
- R3: A CPU write with bit 0 = 1, where bit 7 is 0 after the write, sets the read-start bit for exactly one cycle. `memRdStb` is high in that cycle, and hardware then clears the bit.
- R4: Bits 1 and 0 are set-only. Writing 0 to them never clears them, so a busy write keeps bit 1 at 1 across such a write.
- R5: A read request is refused when bit 7 is 1 after the write. Bit 0 stays 0 and `memRdStb` stays low.
- R6: A start needs write enable. A CPU write with bit 1 = 1 starts an operation only if the same written value has bit 2 = 1. Otherwise bit 1 stays 0 and no start strobe is issued.
- R7: An accepted start sets bit 1 and pulses, for one cycle after the write's edge, either `memWrStb` (bit 4 = 0) or `memErStb` (bit 4 = 1). Bit 1 then stays 1 for PROG_CYCLES cycles in total and clears by itself.
- R8: When an operation completes, hardware clears bit 1, clears the row-erase bit 4 and clears the error flag bit 3, all on the same edge.
- R9: While bit 1 is 1, CPU writes to bits 7, 6 and 4 are ignored.
- R10: A warm reset while bit 1 is 1 does the following. It sets bit 3. It keeps bits 7 and 6. It clears bits 4, 2, 1 and 0. It stops the operation, so no start strobe follows and no completion follows.
- R11: A warm reset while idle clears bits 4, 2, 1 and 0. It leaves bits 7, 6 and 3 unchanged.
- R12: A CPU write at an address other than REG_ADDR has no effect. `cpuRdata` reads 0x00 whenever `cpuAddr` differs from REG_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Synchronous power-on reset, active high |
| warmRst | input | 1 | Synchronous warm reset, active high |
| cpuWe | input | 1 | CPU write request |
| cpuAddr | input | ADDR_W | CPU register address |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | Register readback, 0 when the address does not match |
| memRdStb | output | 1 | One-cycle read strobe |
| memWrStb | output | 1 | One-cycle write-start strobe |
| memErStb | output | 1 | One-cycle row-erase-start strobe |
| memSelProg | output | 1 | Target is program flash |
| memSelCfg | output | 1 | Target is configuration space |

## Verification
The bench drives a set of targeted cases:
- A write of 0 to a busy start bit. A design that let software clear the bit would abort the operation early.
- A read request made together with the program-flash select. A design that ignored the refusal would strobe the memory back end.
- A start without write enable. A design that did not gate the start would emit a write strobe.
- A row erase followed to completion. A design that did not clear the erase bit automatically would turn the next start into another erase.
- Select bits rewritten mid-write. A design that accepted them would retarget the operation in flight.
- A warm reset mid-write. A design that got this wrong would either lose the error flag or wipe the select bits needed to trace the failure.

// File: rtl/nvmCtlPkg.sv
`timescale 1ns/1ps
package nvmCtlPkg;
  localparam int REG_W = 8;

  // Strobes from the sequencer to the register bits
  typedef struct packed {
    logic por;    // power-on clear
    logic warm;   // warm reset abort
    logic ldCfg;  // load select and erase bits (idle only)
    logic ldCom;  // load write enable and error flag
    logic setWr;  // accepted start
    logic setRd;  // accepted read
    logic clrRd;  // read finished
    logic done;   // programming finished
  } nvmStb_t;
endpackage

// File: rtl/nvmCtlBits.sv
`timescale 1ns/1ps
module nvmCtlBits
  import nvmCtlPkg::*;
(
  input  logic             clk,
  input  nvmStb_t          stb,
  input  logic [REG_W-1:0] wd,
  output logic [REG_W-1:0] image
);
  logic selProgQ, selCfgQ, freeQ, errQ, wrenQ, wrQ, rdQ;

  always_ff @(posedge clk) begin
    if (stb.por) begin
      selProgQ <= 1'b0;
      selCfgQ  <= 1'b0;
      freeQ    <= 1'b0;
      errQ     <= 1'b0;
      wrenQ    <= 1'b0;
      wrQ      <= 1'b0;
      rdQ      <= 1'b0;
    end else if (stb.warm) begin
      freeQ <= 1'b0;
      wrenQ <= 1'b0;
      wrQ   <= 1'b0;
      rdQ   <= 1'b0;
      errQ  <= errQ | wrQ;
    end else begin
      if (stb.ldCfg) begin
        selProgQ <= wd[7];
        selCfgQ  <= wd[6];
        freeQ    <= wd[4];
      end
      if (stb.ldCom) begin
        wrenQ <= wd[2];
        errQ  <= wd[3];
      end
      if (stb.setWr) wrQ <= 1'b1;
      if (stb.clrRd) rdQ <= 1'b0;
      if (stb.setRd) rdQ <= 1'b1;
      if (stb.done) begin
        wrQ   <= 1'b0;
        freeQ <= 1'b0;
        errQ  <= 1'b0;
      end
    end
  end

  assign image = {selProgQ, selCfgQ, 1'b0, freeQ, errQ, wrenQ, wrQ, rdQ};

  // R3: a read bit lasts one cycle unless re-requested
  p_rd_single_r3: assert property (@(posedge clk) disable iff (stb.por || stb.warm)
    (rdQ && !stb.setRd) |=> !rdQ);
  // R5: a pending read never coexists with program flash select
  p_rd_refused_r5: assert property (@(posedge clk) disable iff (stb.por || stb.warm)
    rdQ |-> !selProgQ);
  // R6: a start only appears with write enable set
  p_wr_needs_wren_r6: assert property (@(posedge clk) disable iff (stb.por || stb.warm)
    $rose(wrQ) |-> wrenQ);
  // R9: target bits hold while busy
  p_sel_frozen_r9: assert property (@(posedge clk) disable iff (stb.por || stb.warm)
    $past(wrQ) |-> ($stable(selProgQ) && $stable(selCfgQ)));
  // R10: warm abort of a busy write records the error
  p_warm_err_r10: assert property (@(posedge clk) disable iff (stb.por)
    (stb.warm && wrQ) |=> (errQ && !wrQ));
endmodule

// File: rtl/nvmCtlSeq.sv
`timescale 1ns/1ps
module nvmCtlSeq
  import nvmCtlPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int REG_ADDR    = 8'hA6,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              warmRst,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [REG_W-1:0]  wd,
  input  logic [REG_W-1:0]  image,
  output nvmStb_t           stb,
  output logic              memWrStb,
  output logic              memErStb
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  logic          busy, hit, cpuCyc, newProg, startQ;
  logic [CW-1:0] cnt;

  assign busy    = image[1];
  assign hit     = cpuWe && (cpuAddr == ADDR_W'(REG_ADDR));
  assign cpuCyc  = hit && !porRst && !warmRst;
  assign newProg = busy ? image[7] : wd[7];

  always_comb begin
    stb       = '0;
    stb.por   = porRst;
    stb.warm  = warmRst;
    stb.ldCfg = cpuCyc && !busy;
    stb.ldCom = cpuCyc;
    stb.setWr = cpuCyc && !busy && wd[1] && wd[2];
    stb.setRd = cpuCyc && wd[0] && !newProg;
    stb.clrRd = image[0];
    stb.done  = busy && (cnt == LAST) && !porRst && !warmRst;
  end

  always_ff @(posedge clk) begin
    if (porRst || warmRst) begin
      cnt    <= '0;
      startQ <= 1'b0;
    end else begin
      startQ <= stb.setWr;
      if (stb.setWr || stb.done) cnt <= '0;
      else if (busy)             cnt <= cnt + 1'b1;
    end
  end

  assign memWrStb = startQ && !image[4];
  assign memErStb = startQ && image[4];

  // R7: write and erase starts are exclusive single pulses
  p_start_kind_r7: assert property (@(posedge clk) disable iff (porRst || warmRst)
    $onehot0({memWrStb, memErStb}));
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (porRst || warmRst)
    (memWrStb || memErStb) |=> !(memWrStb || memErStb));
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (porRst || warmRst)
    cnt <= LAST);
  // R8: completion drops the busy bit and erase bit
  p_done_clears_r8: assert property (@(posedge clk) disable iff (porRst || warmRst)
    stb.done |=> (!image[1] && !image[4]));
endmodule

// File: rtl/nvmCtlReg.sv
`timescale 1ns/1ps
module nvmCtlReg
  import nvmCtlPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int REG_ADDR    = 8'hA6,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              warmRst,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [REG_W-1:0]  cpuWdata,
  output logic [REG_W-1:0]  cpuRdata,
  output logic              memRdStb,
  output logic              memWrStb,
  output logic              memErStb,
  output logic              memSelProg,
  output logic              memSelCfg
);
  nvmStb_t          stb;
  logic [REG_W-1:0] image;

  nvmCtlSeq #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .PROG_CYCLES(PROG_CYCLES)) uSeq (
    .clk(clk), .porRst(porRst), .warmRst(warmRst), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .wd(cpuWdata), .image(image), .stb(stb), .memWrStb(memWrStb), .memErStb(memErStb)
  );

  nvmCtlBits uBits (.clk(clk), .stb(stb), .wd(cpuWdata), .image(image));

  assign cpuRdata   = (cpuAddr == ADDR_W'(REG_ADDR)) ? image : '0;
  assign memRdStb   = image[0];
  assign memSelProg = image[7];
  assign memSelCfg  = image[6];

  // R2: bit 5 never reads back as 1
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (porRst)
    !cpuRdata[5]);
endmodule

// File: tb/sim_nvmCtlReg.sv
`timescale 1ns/1ps
module sim_nvmCtlReg;
  localparam int PROG = 5;
  localparam logic [7:0] RA = 8'hA6;

  logic clk = 1'b0;
  logic porRst = 1'b1, warmRst = 1'b0, cpuWe = 1'b0;
  logic [7:0] cpuAddr = RA, cpuWdata = 8'h00, cpuRdata;
  logic memRdStb, memWrStb, memErStb, memSelProg, memSelCfg;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nvmCtlReg #(.ADDR_W(8), .REG_ADDR(8'hA6), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .porRst(porRst), .warmRst(warmRst), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .memRdStb(memRdStb), .memWrStb(memWrStb),
    .memErStb(memErStb), .memSelProg(memSelProg), .memSelCfg(memSelCfg)
  );

  typedef struct {
    logic [7:0] d;
    logic rd, wr, er;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  // Driver: apply one cycle of stimulus and queue what must follow the edge
  task automatic cyc(input logic we, input logic [7:0] wd, input logic [7:0] ad,
                     input logic p, input logic w, input logic [7:0] d,
                     input logic r, input logic ws, input logic es, input string tag);
    exp_t x;
    cpuWe = we; cpuWdata = wd; cpuAddr = ad; porRst = p; warmRst = w;
    x.d = d; x.rd = r; x.wr = ws; x.er = es; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] wd, input logic [7:0] d,
                       input logic r, input logic ws, input logic es, input string tag);
    cyc(1'b1, wd, RA, 1'b0, 1'b0, d, r, ws, es, tag);
  endtask

  task automatic idle(input logic [7:0] d, input string tag);
    cyc(1'b0, 8'h00, RA, 1'b0, 1'b0, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare each queued item just after its edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      total++;
      if (cpuRdata !== e.d || memRdStb !== e.rd || memWrStb !== e.wr || memErStb !== e.er
          || memSelProg !== e.d[7] || memSelCfg !== e.d[6]) begin
        bad++;
        $display("FAIL %s: got data=%02h rd=%b wr=%b er=%b exp data=%02h rd=%b wr=%b er=%b",
                 e.tag, cpuRdata, memRdStb, memWrStb, memErStb, e.d, e.rd, e.wr, e.er);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1'b0, 8'h00, RA, 1'b1, 1'b0, 8'h00, 0, 0, 0, "R1 por");
    wrReg(8'hFC, 8'hDC, 0, 0, 0, "R2 layout readback");
    cyc(1'b0, 8'h00, RA, 1'b1, 1'b0, 8'h00, 0, 0, 0, "R1 por clears all");
    cyc(1'b1, 8'hFC, 8'hA7, 1'b0, 1'b0, 8'h00, 0, 0, 0, "R12 other address");
    idle(8'h00, "R12 write had no effect");
    wrReg(8'h01, 8'h01, 1, 0, 0, "R3 read strobe");
    idle(8'h00, "R3 read self clears");
    wrReg(8'h81, 8'h80, 0, 0, 0, "R5 read refused");
    idle(8'h80, "R5 still no read");
    wrReg(8'h00, 8'h00, 0, 0, 0, "R2 clear selects");
    wrReg(8'h02, 8'h00, 0, 0, 0, "R6 start without enable");
    idle(8'h00, "R6 stays idle");
    wrReg(8'h06, 8'h06, 0, 1, 0, "R7 write start");
    wrReg(8'h04, 8'h06, 0, 0, 0, "R4 wr not clearable");
    wrReg(8'hD4, 8'h06, 0, 0, 0, "R9 busy ignores selects");
    idle(8'h06, "R7 busy");
    idle(8'h06, "R7 busy last");
    idle(8'h04, "R7 self clear");
    wrReg(8'h08, 8'h08, 0, 0, 0, "R2 set error flag");
    wrReg(8'h1E, 8'h1E, 0, 0, 1, "R7 erase start");
    for (int i = 1; i < PROG; i++) idle(8'h1E, "R8 erase busy");
    idle(8'h04, "R8 erase bit and error cleared");
    wrReg(8'hC0, 8'hC0, 0, 0, 0, "R2 both selects");
    wrReg(8'hC6, 8'hC6, 0, 1, 0, "R7 start with selects");
    idle(8'hC6, "R7 busy before abort");
    cyc(1'b0, 8'h00, RA, 1'b0, 1'b1, 8'hC8, 0, 0, 0, "R10 warm mid write");
    for (int i = 0; i < PROG; i++) idle(8'hC8, "R10 stays aborted");
    wrReg(8'h54, 8'h54, 0, 0, 0, "R2 idle load");
    cyc(1'b0, 8'h00, RA, 1'b0, 1'b1, 8'h40, 0, 0, 0, "R11 warm when idle");
    cyc(1'b0, 8'h00, RA, 1'b1, 1'b0, 8'h00, 0, 0, 0, "R1 final por");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule